// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit resolves the source operand of a two-operand ALU instruction. A request carries a 4-bit mode code, a base register index, an index register index, a 16-bit displacement, a 16-bit immediate and a 2-bit access-size code. The unit reads the two named registers through a pair of combinational read ports and forms an effective address. It fetches one or two 32-bit words through a request/valid memory read port. It then presents the operand with a one-cycle `done` strobe. The two auto-update modes also write the adjusted base register back in that same cycle. An unknown mode code raises a one-cycle `bad_mode` strobe in place of `done`.

The sequencer has six named states. IDLE waits for `start`. CALC samples the register ports and evaluates the address. READ1 and READ2 each hold a memory request until `mem_valid` arrives. DONE and BAD are one-cycle result states. The transitions are as follows:
- IDLE→CALC on `start`.
- CALC→BAD on an illegal code, CALC→DONE for the modes without a memory access, and CALC→READ1 otherwise.
- READ1→READ2 on `mem_valid` for the memory-indirect mode only, and READ1→DONE on `mem_valid` for every other memory mode.
- READ2→DONE on `mem_valid`.
- DONE→IDLE and BAD→IDLE unconditionally.

Mode codes are: 0 register, 1 immediate, 2 displacement, 3 register-indirect, 4 indexed, 5 absolute, 6 memory-indirect, 7 auto-increment, 8 auto-decrement, 9 scaled. The step d is 1, 2 or 4 bytes for size codes 0, 1 and 2, and size code 3 is treated as 4. Displacement and immediate are sign-extended to 32 bits.

Top module: `opnd_addr_unit`

## Requirements
- R1: Mode 0 delivers the value of the base register as the operand and issues no memory read.
- R2: Mode 1 delivers the sign-extended immediate as the operand and issues no memory read.
- R3: Mode 2 reads one word at base + sign-extended displacement, and mode 3 reads one word at base. The word read is the operand.
- R4: Mode 4 reads one word at base + index. Mode 5 reads one word at the sign-extended displacement used as an absolute address.
- R5: Mode 6 reads a pointer at the base address, then reads the operand at that pointer, in that order.
- R6: Mode 7 reads at base and writes back base + d. Mode 8 reads at base − d and writes back base − d. For both modes the write-back register index equals the base index.
- R7: Mode 9 reads one word at base + sign-extended displacement + index × d.
- R8: Codes 10 to 15 produce a single `bad_mode` pulse two cycles after the start edge. They produce no `done`, no memory read and no write-back.
- R9: `mem_req` stays high with an unchanged `mem_addr` until the cycle in which `mem_valid` is seen.
- R10: `done` is a single-cycle pulse. It rises 2 + the total cycles spent in the read states after the start edge, where each read state lasts until `mem_valid` is sampled.
- R11: `wb_en` is high for exactly one cycle, only in modes 7 and 8, and only together with `done`.
- R12: `start` is ignored from the cycle after it is accepted up to and including the `done` or `bad_mode` cycle. Input changes in that window do not affect the result.
- R13: After reset, `done`, `bad_mode`, `wb_en` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | New request, accepted only in IDLE |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 4 | Base register index |
| index_sel | input | 4 | Index register index |
| disp | input | 16 | Displacement or absolute address |
| imm | input | 16 | Immediate constant |
| size | input | 2 | Access size code (0:1, 1:2, 2/3:4 bytes) |
| rf_sel_a | output | 4 | Register read port A index |
| rf_data_a | input | 32 | Register read port A data |
| rf_sel_b | output | 4 | Register read port B index |
| rf_data_b | input | 32 | Register read port B data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Operand valid strobe |
| operand | output | 32 | Resolved operand |
| bad_mode | output | 1 | Illegal mode strobe |
| wb_en | output | 1 | Base write-back enable |
| wb_sel | output | 4 | Base write-back register index |
| wb_data | output | 32 | Base write-back value |

## Verification
Operand delivery and base write-back land in the same cycle in the auto-update modes. In auto-decrement, the written value must also equal the address already used for the read. The bench runs both auto modes at every size code with memory latencies above zero. It checks `done`, `operand`, `wb_en`, `wb_sel` and `wb_data` together in the predicted cycle, and checks the logged read address against the write-back value. A second collision is a fresh `start` arriving while a request is still in flight. The bench holds `start` high through the `done` cycle with scrambled fields, including an illegal mode code. It then confirms the original result, the original addresses, and no extra strobe afterwards.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    typedef enum logic [3:0] {
        AM_REG   = 4'd0,
        AM_IMM   = 4'd1,
        AM_DISP  = 4'd2,
        AM_RIND  = 4'd3,
        AM_INDEX = 4'd4,
        AM_ABS   = 4'd5,
        AM_MIND  = 4'd6,
        AM_AINC  = 4'd7,
        AM_ADEC  = 4'd8,
        AM_SCALE = 4'd9
    } amode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALC,
        ST_READ1,
        ST_READ2,
        ST_DONE,
        ST_BAD
    } seq_state_e;

endpackage

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc
    import opnd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic [3:0]        mode,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    input  logic [OFS_W-1:0]  disp,
    input  logic [OFS_W-1:0]  imm,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] ea,
    output logic [DATA_W-1:0] new_base,
    output logic [DATA_W-1:0] direct_val,
    output logic [1:0]        nreads,
    output logic              legal,
    output logic              upd
);

    localparam int EXT_W = DATA_W - OFS_W;

    logic [DATA_W-1:0] disp_x;
    logic [DATA_W-1:0] imm_x;
    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] scaled;
    logic [1:0]        shamt;

    // Sign extension of the short fields; the variant depends on the widths.
    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_x = {{EXT_W{disp[OFS_W-1]}}, disp};
            assign imm_x  = {{EXT_W{imm[OFS_W-1]}}, imm};
        end else begin : g_noext
            assign disp_x = disp[DATA_W-1:0];
            assign imm_x  = imm[DATA_W-1:0];
        end
    endgenerate

    // Size code 3 is treated like code 2 (four bytes).
    assign shamt  = (size == 2'd3) ? 2'd2 : size;
    assign step   = {{(DATA_W-1){1'b0}}, 1'b1} << shamt;
    assign scaled = index << shamt;

    always_comb begin
        ea         = base;
        new_base   = base;
        direct_val = base;
        nreads     = 2'd1;
        legal      = 1'b1;
        upd        = 1'b0;
        case (amode_e'(mode))
            AM_REG: begin
                nreads = 2'd0;
            end
            AM_IMM: begin
                nreads     = 2'd0;
                direct_val = imm_x;
            end
            AM_DISP: begin
                ea = base + disp_x;
            end
            AM_RIND: begin
                ea = base;
            end
            AM_INDEX: begin
                ea = base + index;
            end
            AM_ABS: begin
                ea = disp_x;
            end
            AM_MIND: begin
                nreads = 2'd2;
            end
            AM_AINC: begin
                upd      = 1'b1;
                new_base = base + step;
            end
            AM_ADEC: begin
                upd      = 1'b1;
                new_base = base - step;
                ea       = base - step;
            end
            AM_SCALE: begin
                ea = base + disp_x + scaled;
            end
            default: begin
                legal  = 1'b0;
                nreads = 2'd0;
            end
        endcase
    end

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
    import opnd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode_i,
    input  logic [IDX_W-1:0]  a_idx_i,
    input  logic [IDX_W-1:0]  b_idx_i,
    input  logic [OFS_W-1:0]  disp_i,
    input  logic [OFS_W-1:0]  imm_i,
    input  logic [1:0]        size_i,
    output logic [3:0]        mode_q,
    output logic [IDX_W-1:0]  a_idx_q,
    output logic [IDX_W-1:0]  b_idx_q,
    output logic [OFS_W-1:0]  disp_q,
    output logic [OFS_W-1:0]  imm_q,
    output logic [1:0]        size_q,
    input  logic [DATA_W-1:0] ea,
    input  logic [DATA_W-1:0] new_base,
    input  logic [DATA_W-1:0] direct_val,
    input  logic [1:0]        nreads,
    input  logic              legal,
    input  logic              upd,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] operand,
    output logic              bad_mode,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data
);

    seq_state_e        st_q, st_d;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] nbase_q;
    logic              chain_q;
    logic              upd_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_CALC;
            ST_CALC: begin
                if (!legal)              st_d = ST_BAD;
                else if (nreads == 2'd0) st_d = ST_DONE;
                else                     st_d = ST_READ1;
            end
            ST_READ1: if (mem_valid) st_d = chain_q ? ST_READ2 : ST_DONE;
            ST_READ2: if (mem_valid) st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            ST_BAD:   st_d = ST_IDLE;
        endcase
    end

    // Request fields and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            a_idx_q <= '0;
            b_idx_q <= '0;
            disp_q  <= '0;
            imm_q   <= '0;
            size_q  <= '0;
            addr_q  <= '0;
            opnd_q  <= '0;
            nbase_q <= '0;
            chain_q <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= mode_i;
                        a_idx_q <= a_idx_i;
                        b_idx_q <= b_idx_i;
                        disp_q  <= disp_i;
                        imm_q   <= imm_i;
                        size_q  <= size_i;
                    end
                end
                ST_CALC: begin
                    addr_q  <= ea;
                    nbase_q <= new_base;
                    opnd_q  <= direct_val;
                    chain_q <= (nreads == 2'd2);
                    upd_q   <= legal && upd;
                end
                ST_READ1: begin
                    if (mem_valid) begin
                        if (chain_q) addr_q <= mem_rdata;
                        else         opnd_q <= mem_rdata;
                    end
                end
                ST_READ2: begin
                    if (mem_valid) opnd_q <= mem_rdata;
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req  = (st_q == ST_READ1) || (st_q == ST_READ2);
        mem_addr = addr_q;
        done     = (st_q == ST_DONE);
        bad_mode = (st_q == ST_BAD);
        operand  = opnd_q;
        wb_en    = (st_q == ST_DONE) && upd_q;
        wb_idx   = a_idx_q;
        wb_data  = nbase_q;
    end

    // Request held steady until the memory answers (R9)
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // Operand strobe lasts one cycle (R10)
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Write-back only alongside the operand strobe (R11)
    assert_wb_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // Illegal code never follows a memory read (R8)
    assert_bad_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_mode |-> !$past(mem_req));

    // Pre-decrement reads at the already updated base (R6)
    assert_adec_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mode_q == AM_ADEC)) |-> (mem_addr == nbase_q));

    // New start while busy leaves the captured request alone (R12)
    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (st_q != ST_IDLE)) |=> ($stable(mode_q) && $stable(a_idx_q)));

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
    import opnd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [IDX_W-1:0]  base_sel,
    input  logic [IDX_W-1:0]  index_sel,
    input  logic [OFS_W-1:0]  disp,
    input  logic [OFS_W-1:0]  imm,
    input  logic [1:0]        size,
    output logic [IDX_W-1:0]  rf_sel_a,
    input  logic [DATA_W-1:0] rf_data_a,
    output logic [IDX_W-1:0]  rf_sel_b,
    input  logic [DATA_W-1:0] rf_data_b,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [DATA_W-1:0] operand,
    output logic              bad_mode,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_sel,
    output logic [DATA_W-1:0] wb_data
);

    logic [3:0]        mode_q;
    logic [IDX_W-1:0]  a_idx_q;
    logic [IDX_W-1:0]  b_idx_q;
    logic [OFS_W-1:0]  disp_q;
    logic [OFS_W-1:0]  imm_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] ea;
    logic [DATA_W-1:0] new_base;
    logic [DATA_W-1:0] direct_val;
    logic [1:0]        nreads;
    logic              legal;
    logic              upd;

    assign rf_sel_a = a_idx_q;
    assign rf_sel_b = b_idx_q;

    opnd_ea_calc #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_calc (
        .mode       (mode_q),
        .base       (rf_data_a),
        .index      (rf_data_b),
        .disp       (disp_q),
        .imm        (imm_q),
        .size       (size_q),
        .ea         (ea),
        .new_base   (new_base),
        .direct_val (direct_val),
        .nreads     (nreads),
        .legal      (legal),
        .upd        (upd)
    );

    opnd_seq #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .OFS_W  (OFS_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_i     (mode),
        .a_idx_i    (base_sel),
        .b_idx_i    (index_sel),
        .disp_i     (disp),
        .imm_i      (imm),
        .size_i     (size),
        .mode_q     (mode_q),
        .a_idx_q    (a_idx_q),
        .b_idx_q    (b_idx_q),
        .disp_q     (disp_q),
        .imm_q      (imm_q),
        .size_q     (size_q),
        .ea         (ea),
        .new_base   (new_base),
        .direct_val (direct_val),
        .nreads     (nreads),
        .legal      (legal),
        .upd        (upd),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_valid  (mem_valid),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .operand    (operand),
        .bad_mode   (bad_mode),
        .wb_en      (wb_en),
        .wb_idx     (wb_sel),
        .wb_data    (wb_data)
    );

endmodule

// File: tb/opnd_addr_unit_test.sv
`timescale 1ns/1ps
module opnd_addr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [3:0]  base_sel = '0;
    logic [3:0]  index_sel = '0;
    logic [15:0] disp = '0;
    logic [15:0] imm = '0;
    logic [1:0]  size = '0;
    logic [3:0]  rf_sel_a, rf_sel_b;
    logic [31:0] rf_data_a, rf_data_b;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, bad_mode, wb_en;
    logic [31:0] operand, wb_data;
    logic [3:0]  wb_sel;

    logic [31:0] regs [16];
    logic [31:0] addr_log [$];
    int          mem_lat = 0;
    int          mem_cnt = 0;
    int          n_checks = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    assign rf_data_a = regs[rf_sel_a];
    assign rf_data_b = regs[rf_sel_b];

    opnd_addr_unit uut (
        .clk (clk), .rst_n (rst_n), .start (start), .mode (mode),
        .base_sel (base_sel), .index_sel (index_sel), .disp (disp), .imm (imm),
        .size (size), .rf_sel_a (rf_sel_a), .rf_data_a (rf_data_a),
        .rf_sel_b (rf_sel_b), .rf_data_b (rf_data_b), .mem_req (mem_req),
        .mem_addr (mem_addr), .mem_valid (mem_valid), .mem_rdata (mem_rdata),
        .done (done), .operand (operand), .bad_mode (bad_mode), .wb_en (wb_en),
        .wb_sel (wb_sel), .wb_data (wb_data)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    // Behavioural memory: answers after mem_lat waiting cycles, one-cycle valid.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_cnt = 0;
        end else if (mem_valid) begin
            mem_valid <= 1'b0;
        end else if (mem_req) begin
            if (mem_cnt >= mem_lat) begin
                mem_valid <= 1'b1;
                mem_rdata <= memf(mem_addr);
                addr_log.push_back(mem_addr);
                mem_cnt = 0;
            end else begin
                mem_cnt++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One request with a cycle-by-cycle reference of every strobe.
    task automatic run(input logic [3:0] md, input int a, input int b,
                       input logic [15:0] dp, input logic [15:0] im,
                       input logic [1:0] sz, input int lat, input bit hold,
                       input string tag);
        logic [31:0] base, idx, d, dx, ix, exp_op, exp_wb;
        logic [31:0] exp_addr [$];
        bit legal, upd;
        int sh, nrd, dn;
        base = regs[a];
        idx = regs[b];
        sh = (sz == 2'd3) ? 2 : int'(sz);
        d = 32'd1 << sh;
        dx = {{16{dp[15]}}, dp};
        ix = {{16{im[15]}}, im};
        legal = 1'b1;
        upd = 1'b0;
        exp_op = '0;
        exp_wb = base;
        case (md)
            4'd0: exp_op = base;
            4'd1: exp_op = ix;
            4'd2: exp_addr.push_back(base + dx);
            4'd3: exp_addr.push_back(base);
            4'd4: exp_addr.push_back(base + idx);
            4'd5: exp_addr.push_back(dx);
            4'd6: begin exp_addr.push_back(base); exp_addr.push_back(memf(base)); end
            4'd7: begin exp_addr.push_back(base); upd = 1'b1; exp_wb = base + d; end
            4'd8: begin upd = 1'b1; exp_wb = base - d; exp_addr.push_back(exp_wb); end
            4'd9: exp_addr.push_back(base + dx + (idx << sh));
            default: legal = 1'b0;
        endcase
        if (exp_addr.size() > 0) exp_op = memf(exp_addr[exp_addr.size()-1]);
        nrd = exp_addr.size();
        dn = 2 + nrd * (lat + 1) + ((nrd > 1) ? 1 : 0);
        mem_lat = lat;
        addr_log.delete();
        @(negedge clk);
        mode = md; base_sel = a[3:0]; index_sel = b[3:0];
        disp = dp; imm = im; size = sz; start = 1'b1;
        for (int j = 1; j <= dn + 2; j++) begin
            @(negedge clk);
            if (hold && j <= dn) begin
                start = 1'b1;
                mode = 4'hF; base_sel = ~a[3:0]; disp = ~dp; size = ~sz;
            end else begin
                start = 1'b0;
            end
            chk("R10", "done timing", {31'd0, done}, {31'd0, (j == dn) && legal});
            chk("R8", "bad_mode timing", {31'd0, bad_mode}, {31'd0, (j == dn) && !legal});
            chk("R11", "wb_en timing", {31'd0, wb_en}, {31'd0, (j == dn) && upd});
            if (j == dn && legal) begin
                chk(tag, "operand", operand, exp_op);
                if (upd) begin
                    chk("R6", "wb_data", wb_data, exp_wb);
                    chk("R6", "wb_sel", {28'd0, wb_sel}, a);
                end
            end
        end
        chk(tag, "read count", addr_log.size(), nrd);
        for (int k = 0; k < nrd && k < addr_log.size(); k++)
            chk(tag, "read address", addr_log[k], exp_addr[k]);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + i * 32'h0001_0104;
        regs[3] = 32'h0000_2000;
        regs[5] = 32'h0000_0010;
        regs[7] = 32'hFFFF_FFF0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13", "done in reset", {31'd0, done}, 32'd0);
        chk("R13", "bad_mode in reset", {31'd0, bad_mode}, 32'd0);
        chk("R13", "wb_en in reset", {31'd0, wb_en}, 32'd0);
        chk("R13", "mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "done after reset", {31'd0, done}, 32'd0);
        chk("R13", "mem_req after reset", {31'd0, mem_req}, 32'd0);

        run(4'd0, 7, 0, 16'h0000, 16'h0000, 2'd0, 0, 0, "R1");
        run(4'd0, 3, 5, 16'h1234, 16'h4321, 2'd2, 0, 0, "R1");
        run(4'd1, 2, 0, 16'h0000, 16'h8001, 2'd0, 0, 0, "R2");
        run(4'd1, 2, 0, 16'h0000, 16'h7FFF, 2'd0, 0, 0, "R2");
        run(4'd2, 3, 0, 16'hFFF0, 16'h0000, 2'd0, 2, 0, "R3");
        run(4'd2, 7, 0, 16'h0020, 16'h0000, 2'd0, 0, 0, "R3");
        run(4'd3, 3, 0, 16'h0000, 16'h0000, 2'd0, 1, 0, "R3");
        run(4'd4, 3, 5, 16'h0000, 16'h0000, 2'd0, 0, 0, "R4");
        run(4'd5, 0, 0, 16'h8000, 16'h0000, 2'd0, 1, 0, "R4");
        run(4'd5, 0, 0, 16'h0ABC, 16'h0000, 2'd0, 0, 0, "R4");
        run(4'd6, 3, 0, 16'h0000, 16'h0000, 2'd0, 1, 0, "R5");
        run(4'd6, 9, 0, 16'h0000, 16'h0000, 2'd0, 0, 0, "R5");
        for (int s = 0; s < 4; s++) begin
            run(4'd7, 3, 0, 16'h0000, 16'h0000, s[1:0], 1, 0, "R6");
            run(4'd8, 3, 0, 16'h0000, 16'h0000, s[1:0], 2, 0, "R6");
        end
        run(4'd9, 3, 5, 16'h0004, 16'h0000, 2'd2, 0, 0, "R7");
        run(4'd9, 3, 5, 16'hFFFC, 16'h0000, 2'd1, 1, 0, "R7");
        run(4'd9, 3, 5, 16'h0000, 16'h0000, 2'd0, 0, 0, "R7");
        run(4'd10, 3, 5, 16'h0000, 16'h0000, 2'd0, 0, 0, "R8");
        run(4'd15, 3, 5, 16'h0000, 16'h0000, 2'd0, 0, 0, "R8");
        // R9 long latency, R12 start held high with scrambled fields
        run(4'd2, 3, 0, 16'h0040, 16'h0000, 2'd0, 4, 0, "R9");
        run(4'd6, 3, 0, 16'h0000, 16'h0000, 2'd0, 3, 1, "R12");
        run(4'd8, 7, 0, 16'h0000, 16'h0000, 2'd1, 2, 1, "R12");
        run(4'd0, 5, 0, 16'h0000, 16'h0000, 2'd0, 0, 1, "R12");

        summary();
        $finish;
    end

endmodule